// File: doc/BRIEF.md
# Programmable Generic Clock Generator

This block drives a bank of general-purpose clock outputs, one per channel, from a single system clock. Each channel has one control word. The control word picks one of four sources: the oscillator or the PLL of one of two source pairs. It can switch in an even-ratio divider, and it gates the output on and off. Each source is given as a one-cycle strobe on the system clock, and each strobe marks one edge (a half period) of that source. A channel toggles its output after a set number of strobes from its selected source, so every output is a registered, 50%-duty signal that is synchronous to the system clock.

Software writes and reads the control words through a simple word-addressed register port. The word for channel n sits at a base offset plus 4·n. The rest of the chip consumes the outputs as clocks or clock enables. A change of source or divider never produces a shortened pulse, and turning a channel off always lets its current high phase finish.

Top module: `gclk_gen`

## Requirements
- R1: After a synchronous reset every output is low, every control word reads as zero and read data is zero.
- R2: The control word of channel n is at byte address BASE + 4·n. A write stores all CTRL_W bits, and a read returns exactly the last written word one clock after the address is presented.
- R3: A write to an address below BASE, not a multiple of four from BASE, or with channel index ≥ NCH changes no control word, and a read of such an address returns zero.
- R4: The source index is {bit 2, bit 1} of the control word. Bit 2 picks the second pair when set, and bit 1 picks the PLL over the oscillator when set. Tick line 0 is oscillator A, 1 is PLL A, 2 is oscillator B and 3 is PLL B. Ticks on the three unselected lines have no effect on the output.
- R5: With the divide-enable bit (bit 3) clear, the output toggles on every tick of the selected source, so its frequency equals the source frequency.
- R6: With bit 3 set, each output level lasts 2·(DIV+1) ticks, where DIV is the field at bits [8 +: DIV_W]. The output frequency is the source frequency divided by 2·(DIV+1), with 50% duty.
- R7: When the enable bit (bit 0) is cleared during a high phase, that phase runs to its full length, the output then falls and it stays low. While the channel is disabled and the output is low, the output never rises.
- R8: A new source, divide-enable or DIV value takes effect only while the output is low. A high phase in progress keeps its old source and length, and the low phase that follows uses the new setting in full.
- R9: Channels are independent: configuring or clocking one channel leaves the outputs of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the control word |
| reg_wdata | input | CTRL_W | Write data |
| reg_rdata | output | CTRL_W | Read data, registered, one cycle after reg_addr |
| src_tick | input | 4 | Source edge strobes: osc A, PLL A, osc B, PLL B |
| gclk_out | output | NCH | Registered generic clock outputs |

## Verification
The bench builds the block with eight channels and a 3-bit DIV field. With that setting it can sweep every divider value, and the undivided mode, on every one of the four sources, and it rotates the runs across all channels. Half-period lengths are counted in source ticks and compared with 2·(DIV+1), or with 1 when the divider is off. Directed runs then change the source and the divider in mid-high-phase, clear the enable during a high phase, and probe misaligned, low and out-of-range addresses.

// File: rtl/gclk_pkg.sv
package gclk_pkg;
  // Control word field positions
  localparam int unsigned GC_EN_BIT    = 0;
  localparam int unsigned GC_PLL_BIT   = 1;
  localparam int unsigned GC_OSC_BIT   = 2;
  localparam int unsigned GC_DIVEN_BIT = 3;
  localparam int unsigned GC_DIV_LSB   = 8;
  localparam int unsigned GC_NSRC      = 4;

  // Source index = {pair select, pll select}
  typedef enum logic [1:0] {
    SRC_OSC_A = 2'd0,
    SRC_PLL_A = 2'd1,
    SRC_OSC_B = 2'd2,
    SRC_PLL_B = 2'd3
  } gc_src_e;
endpackage

// File: rtl/gclk_regs.sv
module gclk_regs
  import gclk_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CTRL_W = 32,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 8,
  parameter int BASE   = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_we,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [CTRL_W-1:0]           reg_wdata,
  output logic [CTRL_W-1:0]           reg_rdata,
  output logic [NCH-1:0]              cfg_en,
  output logic [NCH-1:0][1:0]         cfg_sel,
  output logic [NCH-1:0]              cfg_den,
  output logic [NCH-1:0][DIV_W-1:0]   cfg_div
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] NCH_A  = ADDR_W'(NCH);

  logic [CTRL_W-1:0] ctrl_q [NCH];
  logic [CTRL_W-1:0] rdata_q;
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] word_idx;
  logic [IDX_W-1:0]  idx_s;
  logic              hit;

  assign off      = reg_addr - BASE_A;
  assign word_idx = off >> 2;
  assign idx_s    = word_idx[IDX_W-1:0];
  assign hit      = (reg_addr >= BASE_A) && (off[1:0] == 2'b00) && (word_idx < NCH_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) ctrl_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (reg_we && hit) ctrl_q[idx_s] <= reg_wdata;
      rdata_q <= hit ? ctrl_q[idx_s] : '0;
    end
  end

  assign reg_rdata = rdata_q;

  for (genvar g = 0; g < NCH; g++) begin : g_fields
    assign cfg_en[g]  = ctrl_q[g][GC_EN_BIT];
    assign cfg_sel[g] = {ctrl_q[g][GC_OSC_BIT], ctrl_q[g][GC_PLL_BIT]};
    assign cfg_den[g] = ctrl_q[g][GC_DIVEN_BIT];
    assign cfg_div[g] = ctrl_q[g][GC_DIV_LSB +: DIV_W];
  end

  // R2: an accepted write lands in the addressed word
  assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_we && hit) |=> (ctrl_q[$past(idx_s)] == $past(reg_wdata)));

  // R3: a stray address reads as zero
  assert_stray_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (!hit) |=> (reg_rdata == '0));
endmodule

// File: rtl/gclk_channel.sv
module gclk_channel
  import gclk_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             want_en,
  input  logic [1:0]       want_sel,
  input  logic             want_den,
  input  logic [DIV_W-1:0] want_div,
  input  logic [GC_NSRC-1:0] src_tick,
  output logic             clk_out
);
  localparam int CNT_W = DIV_W + 1;

  logic [1:0]       act_sel;
  logic             act_den;
  logic [DIV_W-1:0] act_div;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;
  logic             out_q;
  logic             tick;
  logic             cfg_diff;

  // Half period minus one: 2*(DIV+1)-1 = {DIV,1}, or 0 when undivided
  assign half_m1  = act_den ? {act_div, 1'b1} : '0;
  assign tick     = src_tick[act_sel];
  assign cfg_diff = (act_sel != want_sel) || (act_den != want_den) || (act_div != want_div);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= 1'b0;
      cnt_q   <= '0;
      act_sel <= SRC_OSC_A;
      act_den <= 1'b0;
      act_div <= '0;
    end else if (!out_q && cfg_diff) begin
      act_sel <= want_sel;
      act_den <= want_den;
      act_div <= want_div;
      cnt_q   <= '0;
    end else if (tick) begin
      if (!out_q && !want_en) begin
        cnt_q <= '0;
      end else if (cnt_q == half_m1) begin
        cnt_q <= '0;
        out_q <= ~out_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign clk_out = out_q;

  // R8: the active setting never moves during a high phase
  assert_cfg_frozen_high_R8: assert property (@(posedge clk) disable iff (rst)
    out_q |=> ($stable(act_sel) && $stable(act_den) && $stable(act_div)));

  // R7: a disabled, low channel stays low
  assert_idle_stays_low_R7: assert property (@(posedge clk) disable iff (rst)
    (!out_q && !want_en) |=> !out_q);

  // R4: only a tick of the active source can move the output
  assert_edge_needs_tick_R4: assert property (@(posedge clk) disable iff (rst)
    (!tick) |=> $stable(out_q));

  // R6: the phase counter stays inside the half period
  assert_cnt_in_half_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= half_m1);
endmodule

// File: rtl/gclk_gen.sv
module gclk_gen
  import gclk_pkg::*;
#(
  parameter int NCH    = 8,
  parameter int CTRL_W = 32,
  parameter int DIV_W  = 8,
  parameter int ADDR_W = 8,
  parameter int BASE   = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic [3:0]        src_tick,
  output logic [NCH-1:0]    gclk_out
);
  logic [NCH-1:0]            cfg_en;
  logic [NCH-1:0][1:0]       cfg_sel;
  logic [NCH-1:0]            cfg_den;
  logic [NCH-1:0][DIV_W-1:0] cfg_div;

  gclk_regs #(
    .NCH(NCH), .CTRL_W(CTRL_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .BASE(BASE)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg_en(cfg_en), .cfg_sel(cfg_sel), .cfg_den(cfg_den), .cfg_div(cfg_div)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    gclk_channel #(.DIV_W(DIV_W)) u_ch (
      .clk(clk), .rst(rst),
      .want_en(cfg_en[g]), .want_sel(cfg_sel[g]),
      .want_den(cfg_den[g]), .want_div(cfg_div[g]),
      .src_tick(src_tick), .clk_out(gclk_out[g])
    );
  end
endmodule

// File: tb/gclk_gen_tb.sv
module gclk_gen_tb;
  localparam int NCH = 8, CTRL_W = 32, DIV_W = 3, ADDR_W = 8, BASE = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [CTRL_W-1:0] reg_wdata = '0;
  logic [CTRL_W-1:0] reg_rdata;
  logic [3:0] src_tick = '0;
  logic [NCH-1:0] gclk_out;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  gclk_gen #(.NCH(NCH), .CTRL_W(CTRL_W), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .BASE(BASE)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .src_tick(src_tick), .gclk_out(gclk_out));

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  function automatic logic [ADDR_W-1:0] ch_addr(input int ch);
    return ADDR_W'(BASE + 4 * ch);
  endfunction

  function automatic logic [31:0] mk(input bit en, input int src, input bit den, input int dv);
    logic [31:0] w = '0;
    w[0] = en; w[1] = src[0]; w[2] = src[1]; w[3] = den;
    w[8 +: DIV_W] = DIV_W'(dv);
    return w;
  endfunction

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic tk(input int s);
    @(negedge clk); src_tick[s] = 1'b1;
    @(negedge clk); src_tick = '0;
  endtask

  // ticks until the output of ch changes; returns tick count
  task automatic to_edge(input int ch, input int s, output int n);
    logic lvl = gclk_out[ch];
    n = 0;
    while (gclk_out[ch] == lvl && n < 40) begin tk(s); n++; end
  endtask

  task automatic park(input int ch, input int s);
    int n = 0;
    wr(ch_addr(ch), '0);
    while (gclk_out[ch] && n < 40) begin tk(s); n++; end
    repeat (2) @(negedge clk);
    check(gclk_out[ch] == 1'b0, "R7", "channel low after park", gclk_out[ch], 0);
  endtask

  task automatic measure(input int ch, input int s, input bit den, input int dv);
    int n;
    int h = den ? 2 * (dv + 1) : 1;
    string rq = den ? "R6" : "R5";
    logic lvl;
    wr(ch_addr(ch), mk(1'b1, s, den, dv));
    repeat (2) @(negedge clk);
    to_edge(ch, s, n);
    check(n < 40, rq, "first edge seen", n, h);
    // unselected sources must not move the output
    lvl = gclk_out[ch];
    for (int o = 0; o < 4; o++) if (o != s) repeat (3) tk(o);
    check(gclk_out[ch] == lvl, "R4", "unselected ticks ignored", gclk_out[ch], lvl);
    for (int k = 0; k < 2; k++) begin
      to_edge(ch, s, n);
      check(n == h, rq, "half period in ticks", n, h);
    end
    check((gclk_out & ~(NCH'(1) << ch)) == '0, "R9", "other channels quiet",
          gclk_out, 0);
    park(ch, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout, expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(gclk_out == '0, "R1", "outputs after reset", gclk_out, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(ch_addr(c), d);
      check(d == '0, "R1", "control word after reset", d, 0);
    end
    // R2: readback of full words
    for (int c = 0; c < NCH; c++) wr(ch_addr(c), 32'h9E3779B9 * (c + 1) & 32'hFFFF_FFFE);
    for (int c = 0; c < NCH; c++) begin
      rd(ch_addr(c), d);
      check(d == (32'h9E3779B9 * (c + 1) & 32'hFFFF_FFFE), "R2", "readback", d,
            32'h9E3779B9 * (c + 1) & 32'hFFFF_FFFE);
    end
    // R3: stray addresses
    wr(ADDR_W'(BASE + 4 * NCH), 32'hFFFF_FFFF);
    wr(ADDR_W'(BASE + 2), 32'hFFFF_FFFF);
    wr(ADDR_W'(BASE - 4), 32'hFFFF_FFFF);
    rd(ADDR_W'(BASE + 4 * NCH), d); check(d == '0, "R3", "index past range reads zero", d, 0);
    rd(ADDR_W'(BASE + 2), d);       check(d == '0, "R3", "misaligned reads zero", d, 0);
    rd(ADDR_W'(BASE - 4), d);       check(d == '0, "R3", "below base reads zero", d, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(ch_addr(c), d);
      check(d == (32'h9E3779B9 * (c + 1) & 32'hFFFF_FFFE), "R3", "word untouched by stray write", d,
            32'h9E3779B9 * (c + 1) & 32'hFFFF_FFFE);
    end
    check(gclk_out == '0, "R9", "no output without ticks", gclk_out, 0);
    for (int c = 0; c < NCH; c++) wr(ch_addr(c), '0);
    repeat (2) @(negedge clk);

    // R4/R5/R6 sweep: every source, undivided and every DIV
    for (int s = 0; s < 4; s++)
      for (int m = 0; m <= (1 << DIV_W); m++)
        measure((s * 9 + m) % NCH, s, m != 0, (m == 0) ? 0 : m - 1);

    // R7: disable during high phase (DIV=1 -> 4 ticks per level)
    wr(ch_addr(0), mk(1'b1, 0, 1'b1, 1));
    repeat (2) @(negedge clk);
    to_edge(0, 0, n);
    check(n == 4 && gclk_out[0], "R6", "first rise after 4 ticks", n, 4);
    tk(0);
    wr(ch_addr(0), mk(1'b0, 0, 1'b1, 1));
    tk(0); tk(0);
    check(gclk_out[0] == 1'b1, "R7", "high phase continues after disable", gclk_out[0], 1);
    tk(0);
    check(gclk_out[0] == 1'b0, "R7", "falls at end of high phase", gclk_out[0], 0);
    repeat (12) tk(0);
    check(gclk_out[0] == 1'b0, "R7", "stays low while disabled", gclk_out[0], 0);
    park(0, 0);

    // R8: divider change in a high phase
    wr(ch_addr(1), mk(1'b1, 1, 1'b1, 0));
    repeat (2) @(negedge clk);
    to_edge(1, 1, n);
    check(gclk_out[1] == 1'b1, "R8", "rise before change", gclk_out[1], 1);
    wr(ch_addr(1), mk(1'b1, 1, 1'b1, 2));
    tk(1);
    check(gclk_out[1] == 1'b1, "R8", "old high phase intact", gclk_out[1], 1);
    tk(1);
    check(gclk_out[1] == 1'b0, "R8", "old high phase length 2", gclk_out[1], 0);
    to_edge(1, 1, n); check(n == 6, "R8", "new low phase length", n, 6);
    to_edge(1, 1, n); check(n == 6, "R8", "new high phase length", n, 6);
    park(1, 1);

    // R8: source change in a high phase
    wr(ch_addr(2), mk(1'b1, 2, 1'b0, 0));
    repeat (2) @(negedge clk);
    tk(2);
    check(gclk_out[2] == 1'b1, "R5", "undivided rise on one tick", gclk_out[2], 1);
    wr(ch_addr(2), mk(1'b1, 3, 1'b0, 0));
    tk(3);
    check(gclk_out[2] == 1'b1, "R8", "new source ignored while high", gclk_out[2], 1);
    tk(2);
    check(gclk_out[2] == 1'b0, "R8", "old source ends high phase", gclk_out[2], 0);
    repeat (2) @(negedge clk);
    tk(3);
    check(gclk_out[2] == 1'b1, "R8", "new source used after low", gclk_out[2], 1);
    park(2, 3);

    summary();
    $finish;
  end
endmodule